// File: doc/BRIEF.md
# Clock Policy Register Controller

This block is a small register file on a simple request/acknowledge bus. It stores one clock-enable mask for each of four clock policies and controls the policy engine that applies them. Every clock has the same bit position in all four masks. A 1 in that position turns the clock on while the matching policy is in effect.

Software unlocks the block by writing a key value to word address 0. Until then, every other write has no effect. To update the masks, software halts the engine through the control register and writes the masks. It then issues a start command that carries exactly one of two mode bits. The start command copies the stored masks into the active set. While the engine runs, the clock-enable output follows the policy selected by a 2-bit input. While the engine is halted, the output holds its last value.

Top module: `clk_policy_regs`

## Requirements
- R1: After reset the block has the following state.
  - Write access is locked.
  - The engine is halted: control bit 0 reads 1 and `eng_run` is 0.
  - The status register reads 0.
  - All four masks read as all ones.
  - `clk_en` is 0.
- R2: Writing `KEY` to address 0 grants write access, and address 0 then reads 1. Writing any other value to address 0 withdraws write access, and address 0 then reads 0.
- R3: While write access is locked, writes to addresses other than 0 change nothing. This covers the mask registers, the start command and the status register.
- R4: While unlocked and halted, a write to address 4+p (p = 0..3) stores bits NCLK-1:0 of the write data as the mask of policy p. Reading address 4+p returns that mask.
- R5: While unlocked and not halted, a mask write is dropped and sets the sticky error flag (status bit 1). The flag stays set until software writes status with bit 1 set.
- R6: A control write with bit 0 set halts the engine. `eng_run` falls after that clock edge, and status bit 0 reads 0.
- R7: A control write while unlocked is a start command when all of the following hold:
  - bit 0 is 0;
  - bit 1 (go) is 1;
  - exactly one of bit 2 (mode A) or bit 3 (mode B) is 1.

  The command's effects follow in order:
  - One edge after the command, the masks are copied to the active set and `eng_run` rises.
  - One edge later, the go bit reads 0 again and `clk_en` shows the new mask.
  - Control bits 3:2 keep the chosen mode.
  - A go with zero or two mode bits is ignored.
- R8: While the engine runs, `clk_en` equals the active mask of policy `pol_sel`, one edge after `pol_sel` changes. While the engine is halted, `clk_en` holds its value.
- R9: Every request is acknowledged on the next edge. Read data arrives with the acknowledge. Addresses 3 and 8 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| ack | output | 1 | Access completed |
| rdata | output | DW | Read data, valid with ack |
| pol_sel | input | 2 | Policy currently selected |
| clk_en | output | NCLK | Enable mask of the policy in effect |
| eng_run | output | 1 | Engine running |

## Verification
The mask writes are tried in three states: locked, unlocked while halted, and unlocked while running. This separates the write being ignored, stored, or dropped with an error. Start commands are sent with one mode bit, which must start the engine, and with both mode bits, which must not. Checks on the cycles after the start command confirm the one-edge latch and the self-clearing go bit. Changing `pol_sel` while running and while halted shows whether the output follows the selector or holds.

// File: rtl/clk_policy_regs.sv
module clk_policy_regs #(
  parameter int NCLK = 8,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [31:0] KEY = 32'h0000_C1A5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  input  logic [1:0]      pol_sel,
  output logic [NCLK-1:0] clk_en,
  output logic            eng_run
);
  localparam int NPOL = 4;

  logic unlocked, halted, go_q, err;
  logic [1:0] mode;
  logic [NPOL-1:0][NCLK-1:0] mask_q, active;
  logic [DW-1:0] rd_mux;

  wire wr     = req & we;
  wire wr_ok  = wr & unlocked;
  wire a_key  = addr == AW'(0);
  wire a_ctl  = addr == AW'(1);
  wire a_sts  = addr == AW'(2);
  wire a_msk  = addr[AW-1:2] == (AW-2)'(1);
  wire [1:0] midx = addr[1:0];

  wire stop_req = wr_ok & a_ctl & wdata[0];
  wire go_req   = wr_ok & a_ctl & ~wdata[0] & wdata[1] & (wdata[2] ^ wdata[3]) & ~go_q;
  wire msk_wr   = wr_ok & a_msk & halted;
  wire msk_drop = wr_ok & a_msk & ~halted;
  wire err_clr  = wr_ok & a_sts & wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      halted   <= 1'b1;
      go_q     <= 1'b0;
      mode     <= 2'b00;
      eng_run  <= 1'b0;
      err      <= 1'b0;
      mask_q   <= '1;
      active   <= '0;
      clk_en   <= '0;
    end else begin
      if (wr && a_key) unlocked <= (wdata == KEY);
      if (stop_req) halted <= 1'b1;
      else if (go_req) halted <= 1'b0;
      go_q <= go_req;
      if (go_req) mode <= wdata[3:2];
      if (stop_req) eng_run <= 1'b0;
      else if (go_q) eng_run <= 1'b1;
      if (go_q) active <= mask_q;
      if (msk_wr) mask_q[midx] <= wdata[NCLK-1:0];
      if (msk_drop) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      if (eng_run) clk_en <= active[pol_sel];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (a_key) rd_mux[0] = unlocked;
    else if (a_ctl) rd_mux[3:0] = {mode, go_q, halted};
    else if (a_sts) rd_mux[1:0] = {err, eng_run};
    else if (a_msk) rd_mux[NCLK-1:0] = mask_q[midx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= (req && !we) ? rd_mux : '0;
    end
  end

  p_locked_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !unlocked) |=> ($stable(mask_q) && $stable(err) && !go_q));
  p_masks_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> $stable(mask_q));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err || $past(req && we && a_sts)));
  p_go_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);
  p_go_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !(req && we && a_ctl)) |=> eng_run);
  p_halt_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && a_ctl && wdata[0] && unlocked) |=> !eng_run);
  p_hold_when_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_run |=> $stable(clk_en));
  p_ack_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);
endmodule

// File: tb/clk_policy_regs_test.sv
module clk_policy_regs_test;
  localparam int NCLK = 8;
  localparam logic [31:0] KEY = 32'h0000_C1A5;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack;
  logic [31:0] rdata;
  logic [1:0] pol_sel = 2'd0;
  logic [NCLK-1:0] clk_en;
  logic eng_run;
  int checks = 0, errors = 0;

  clk_policy_regs #(.NCLK(NCLK), .DW(32), .AW(4), .KEY(KEY)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .pol_sel(pol_sel), .clk_en(clk_en), .eng_run(eng_run));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    check("R9 ack", {31'd0, ack}, 32'd1);
    d = rdata;
    req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 clk_en", {24'd0, clk_en}, 32'd0);
    check("R1 eng_run", {31'd0, eng_run}, 32'd0);
    rd(4'd0, d); check("R1 key", d, 32'd0);
    rd(4'd1, d); check("R1 ctl", d, 32'd1);
    rd(4'd2, d); check("R1 sts", d, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(4'(4 + i), d); check("R1 mask", d, 32'hFF);
    end
    rd(4'd3, d); check("R9 unmapped", d, 32'd0);
    rd(4'd9, d); check("R9 unmapped", d, 32'd0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    wr(4'd5, 32'h3C);
    rd(4'd5, d); check("R3 mask locked", d, 32'hFF);
    wr(4'd1, 32'h6);
    cyc(3);
    rd(4'd2, d); check("R3 go locked", d, 32'd0);
  endtask

  task automatic t_key;
    logic [31:0] d;
    wr(4'd0, KEY);
    rd(4'd0, d); check("R2 unlock", d, 32'd1);
    wr(4'd0, 32'h1234);
    rd(4'd0, d); check("R2 relock", d, 32'd0);
    wr(4'd6, 32'h77);
    rd(4'd6, d); check("R3 mask after relock", d, 32'hFF);
    wr(4'd0, KEY);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(4'(4 + i), 32'h11 << i);
    for (int i = 0; i < 4; i++) begin
      rd(4'(4 + i), d); check("R4 mask store", d, 32'h11 << i);
    end
    wr(4'd1, 32'hE);
    cyc(3);
    rd(4'd2, d); check("R7 two modes ignored", d, 32'd0);
    check("R7 two modes clk_en", {24'd0, clk_en}, 32'd0);
  endtask

  task automatic t_go;
    logic [31:0] d;
    pol_sel = 2'd2;
    wr(4'd1, 32'h6);
    check("R7 not yet running", {31'd0, eng_run}, 32'd0);
    cyc(1);
    check("R7 running after latch", {31'd0, eng_run}, 32'd1);
    check("R7 clk_en not yet", {24'd0, clk_en}, 32'd0);
    cyc(1);
    check("R7 clk_en new", {24'd0, clk_en}, 32'h44);
    rd(4'd1, d); check("R7 go cleared, mode A", d, 32'h4);
  endtask

  task automatic t_follow;
    @(negedge clk); pol_sel = 2'd3;
    @(negedge clk); check("R8 follow p3", {24'd0, clk_en}, 32'h88);
    pol_sel = 2'd0;
    @(negedge clk); check("R8 follow p0", {24'd0, clk_en}, 32'h11);
  endtask

  task automatic t_run_write;
    logic [31:0] d;
    wr(4'd4, 32'h55);
    rd(4'd2, d); check("R5 err set", d, 32'h3);
    cyc(2);
    rd(4'd2, d); check("R5 err sticky", d, 32'h3);
    wr(4'd2, 32'h2);
    rd(4'd2, d); check("R5 err cleared", d, 32'h1);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(4'd1, 32'h1);
    check("R6 eng_run low", {31'd0, eng_run}, 32'd0);
    rd(4'd2, d); check("R6 sts", d, 32'd0);
    pol_sel = 2'd1;
    cyc(2);
    check("R8 hold halted", {24'd0, clk_en}, 32'h11);
    rd(4'd4, d); check("R5 dropped write", d, 32'h11);
    wr(4'd4, 32'h0F);
    rd(4'd4, d); check("R4 write after stop", d, 32'h0F);
    pol_sel = 2'd0;
    wr(4'd1, 32'hA);
    cyc(2);
    check("R7 mode B restart", {24'd0, clk_en}, 32'h0F);
    rd(4'd1, d); check("R7 ctl mode B", d, 32'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_key;
    t_masks;
    t_go;
    t_follow;
    t_run_write;
    t_stop;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule